// File: doc/BRIEF.md
# Cyclic-Prefix Symbol Timing Estimator

This block finds where OFDM symbols begin in a received complex sample stream without any known preamble. Each symbol is an FFT body of 512 samples preceded by a 128-sample guard that copies the body's final 128 samples, so one symbol period is 640 samples. The block multiplies each older sample by the conjugate of the sample 512 positions later and keeps a sliding sum of the latest 128 such products. Where the sliding window lines up with a guard interval, the sum peaks. The peak's complex value also carries the phase rotation caused by a carrier frequency offset.

Every 640 candidate positions, the block reports the candidate with the largest squared magnitude. The report holds that candidate's index within the period and the complex sum at that point. Downstream logic keeps the raw samples in its own buffer. It turns the index into a read pointer at the start of a symbol and derives the frequency offset from the reported sum's angle. Samples arrive under a valid qualifier, and cycles without it are idle.

Top module: `cpsync_timing`

## Requirements
- R1: The reported sum for a candidate whose older window starts at accepted sample c is the sum over j = c+512 .. c+639 of r[j-512]·conj(r[j]). Each product of older sample a+jb and newer sample c'+jd is (ac'+bd) + j(bc'-ad). It appears on outRe and outIm.
- R2: Within a period the winner is the candidate whose sum has the largest re²+im².
- R3: When candidates tie on that magnitude, the one with the lowest index in the period wins.
- R4: Candidate c (counted from 0 at the first sample after reset) belongs to period floor(c/640). outIdx reports c mod 640.
- R5: outValid pulses for exactly one cycle per period of 640 candidates. It is high in the cycle that follows the second rising clock edge counted from the edge that accepts the period's last sample.
- R6: No candidate exists until 640 samples have been accepted after reset, so the first report needs 1279 accepted samples.
- R7: Clock cycles with inValid low change nothing. A stream with idle gaps gives the same reports as the same stream sent without gaps.
- R8: Full-scale 12-bit inputs (every sample -2048-2048j) give a sum of 2^30 + j0 without overflow.
- R9: After reset, outValid, outIdx, outRe and outIm are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Qualifies inRe/inIm as a new sample |
| inRe | input | 12 | Sample real part, signed |
| inIm | input | 12 | Sample imaginary part, signed |
| outValid | output | 1 | One-cycle strobe per period of candidates |
| outIdx | output | 10 | Winning candidate index within its period |
| outRe | output | 32 | Real part of the winning sum, signed |
| outIm | output | 32 | Imaginary part of the winning sum, signed |

## Verification
A sample is taken in at one rising edge, and the sliding sum includes it after that edge. The peak tracker registers the report at the next edge, so outValid is due two edges after the sample that closes a period. The bench samples at falling edges. In the directed full-scale case it holds back one final sample, checks that no report appears before it, then checks at the first falling edge after the second rising edge that outValid is high, and one cycle later that it has dropped. For the random streams, every pulse is compared with a brute-force recomputation of that period's 640 candidates. The stream is sent both with random idle gaps and gapless, and the report count is checked at the end so that a missing or extra strobe is caught.

// File: rtl/cpsync_pkg.sv
package cpsync_pkg;
  // Strobes the controller hands to the peak tracker, registered so they
  // line up with the sliding sum that the correlator updates at the same edge.
  typedef struct packed {
    logic metValid;   // sum register holds a valid candidate this cycle
    logic winFirst;   // candidate is the first of its period
    logic winLast;    // candidate is the last of its period
  } cpsync_strobe_t;
endpackage

// File: rtl/cpsync_ctrl.sv
module cpsync_ctrl
  import cpsync_pkg::*;
#(
  parameter int FFT_LEN = 512,
  parameter int CP_LEN  = 128,
  localparam int SYM_LEN = FFT_LEN + CP_LEN,
  localparam int IDX_W   = $clog2(SYM_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output cpsync_strobe_t   strb,
  output logic [IDX_W-1:0] candIdx
);
  logic [IDX_W-1:0] fillCnt;
  logic [IDX_W-1:0] phase;
  logic             full;

  assign full = (fillCnt == IDX_W'(SYM_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
      phase   <= '0;
      strb    <= '0;
      candIdx <= '0;
    end else begin
      strb.metValid <= inValid && full;
      strb.winFirst <= (phase == '0);
      strb.winLast  <= (phase == IDX_W'(SYM_LEN - 1));
      candIdx       <= phase;
      if (inValid) begin
        if (!full) fillCnt <= fillCnt + 1'b1;
        else if (phase == IDX_W'(SYM_LEN - 1)) phase <= '0;
        else phase <= phase + 1'b1;
      end
    end
  end

  // R6
  fill_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !full |=> !strb.metValid);

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.metValid |-> (candIdx < IDX_W'(SYM_LEN)));
endmodule

// File: rtl/cpsync_corr.sv
module cpsync_corr #(
  parameter int W       = 12,
  parameter int FFT_LEN = 512,
  parameter int CP_LEN  = 128,
  localparam int PROD_W = 2 * W + 1,
  localparam int SUM_W  = PROD_W + $clog2(CP_LEN),
  localparam int DPTR_W = $clog2(FFT_LEN),
  localparam int HPTR_W = $clog2(CP_LEN)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic signed [W-1:0]     inRe,
  input  logic signed [W-1:0]     inIm,
  output logic signed [SUM_W-1:0] sumRe,
  output logic signed [SUM_W-1:0] sumIm
);
  logic signed [W-1:0]      dlyRe  [FFT_LEN];
  logic signed [W-1:0]      dlyIm  [FFT_LEN];
  logic signed [PROD_W-1:0] histRe [CP_LEN];
  logic signed [PROD_W-1:0] histIm [CP_LEN];
  logic [DPTR_W-1:0]        dPtr;
  logic [HPTR_W-1:0]        hPtr;

  logic signed [PROD_W-1:0] aE, bE, cE, dE;
  logic signed [PROD_W-1:0] prodRe, prodIm;
  logic signed [SUM_W-1:0]  addRe, addIm, subRe, subIm;

  // older sample times conjugate of newer sample
  always_comb begin
    aE = {{(PROD_W-W){dlyRe[dPtr][W-1]}}, dlyRe[dPtr]};
    bE = {{(PROD_W-W){dlyIm[dPtr][W-1]}}, dlyIm[dPtr]};
    cE = {{(PROD_W-W){inRe[W-1]}}, inRe};
    dE = {{(PROD_W-W){inIm[W-1]}}, inIm};
    prodRe = aE * cE + bE * dE;
    prodIm = bE * cE - aE * dE;
    addRe = {{(SUM_W-PROD_W){prodRe[PROD_W-1]}}, prodRe};
    addIm = {{(SUM_W-PROD_W){prodIm[PROD_W-1]}}, prodIm};
    subRe = {{(SUM_W-PROD_W){histRe[hPtr][PROD_W-1]}}, histRe[hPtr]};
    subIm = {{(SUM_W-PROD_W){histIm[hPtr][PROD_W-1]}}, histIm[hPtr]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < FFT_LEN; i++) begin
        dlyRe[i] <= '0;
        dlyIm[i] <= '0;
      end
      for (int i = 0; i < CP_LEN; i++) begin
        histRe[i] <= '0;
        histIm[i] <= '0;
      end
      dPtr  <= '0;
      hPtr  <= '0;
      sumRe <= '0;
      sumIm <= '0;
    end else if (inValid) begin
      dlyRe[dPtr]  <= inRe;
      dlyIm[dPtr]  <= inIm;
      histRe[hPtr] <= prodRe;
      histIm[hPtr] <= prodIm;
      sumRe <= sumRe + addRe - subRe;
      sumIm <= sumIm + addIm - subIm;
      dPtr <= (dPtr == DPTR_W'(FFT_LEN - 1)) ? '0 : dPtr + 1'b1;
      hPtr <= (hPtr == HPTR_W'(CP_LEN - 1)) ? '0 : hPtr + 1'b1;
    end
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(sumRe) && $stable(sumIm)));
endmodule

// File: rtl/cpsync_peak.sv
module cpsync_peak
  import cpsync_pkg::*;
#(
  parameter int SUM_W = 32,
  parameter int IDX_W = 10,
  localparam int MAG_W = 2 * SUM_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cpsync_strobe_t          strb,
  input  logic [IDX_W-1:0]        candIdx,
  input  logic signed [SUM_W-1:0] sumRe,
  input  logic signed [SUM_W-1:0] sumIm,
  output logic                    outValid,
  output logic [IDX_W-1:0]        outIdx,
  output logic signed [SUM_W-1:0] outRe,
  output logic signed [SUM_W-1:0] outIm
);
  logic signed [MAG_W-1:0] reE, imE, reSq, imSq;
  logic [MAG_W-1:0]        mag, bestMag;
  logic [IDX_W-1:0]        bestIdx;
  logic signed [SUM_W-1:0] bestRe, bestIm;
  logic                    take;

  always_comb begin
    reE  = {{(MAG_W-SUM_W){sumRe[SUM_W-1]}}, sumRe};
    imE  = {{(MAG_W-SUM_W){sumIm[SUM_W-1]}}, sumIm};
    reSq = reE * reE;
    imSq = imE * imE;
    mag  = $unsigned(reSq) + $unsigned(imSq);
    // strict compare keeps the earliest candidate on a tie
    take = strb.winFirst || (mag > bestMag);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bestMag  <= '0;
      bestIdx  <= '0;
      bestRe   <= '0;
      bestIm   <= '0;
      outValid <= 1'b0;
      outIdx   <= '0;
      outRe    <= '0;
      outIm    <= '0;
    end else begin
      outValid <= 1'b0;
      if (strb.metValid) begin
        if (take) begin
          bestMag <= mag;
          bestIdx <= candIdx;
          bestRe  <= sumRe;
          bestIm  <= sumIm;
        end
        if (strb.winLast) begin
          outValid <= 1'b1;
          outIdx   <= take ? candIdx : bestIdx;
          outRe    <= take ? sumRe : bestRe;
          outIm    <= take ? sumIm : bestIm;
        end
      end
    end
  end

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R5
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strb.metValid && strb.winLast));

  // R2
  best_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.metValid && !strb.winFirst) |=> (bestMag >= $past(bestMag)));
endmodule

// File: rtl/cpsync_timing.sv
module cpsync_timing
  import cpsync_pkg::*;
#(
  parameter int SMP_W   = 12,
  parameter int FFT_LEN = 512,
  parameter int CP_LEN  = 128,
  localparam int SYM_LEN = FFT_LEN + CP_LEN,
  localparam int IDX_W   = $clog2(SYM_LEN),
  localparam int SUM_W   = 2 * SMP_W + 1 + $clog2(CP_LEN)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic signed [SMP_W-1:0] inRe,
  input  logic signed [SMP_W-1:0] inIm,
  output logic                    outValid,
  output logic [IDX_W-1:0]        outIdx,
  output logic signed [SUM_W-1:0] outRe,
  output logic signed [SUM_W-1:0] outIm
);
  cpsync_strobe_t          strb;
  logic [IDX_W-1:0]        candIdx;
  logic signed [SUM_W-1:0] sumRe, sumIm;

  cpsync_ctrl #(.FFT_LEN(FFT_LEN), .CP_LEN(CP_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strb(strb), .candIdx(candIdx)
  );

  cpsync_corr #(.W(SMP_W), .FFT_LEN(FFT_LEN), .CP_LEN(CP_LEN)) uCorr (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inRe(inRe), .inIm(inIm), .sumRe(sumRe), .sumIm(sumIm)
  );

  cpsync_peak #(.SUM_W(SUM_W), .IDX_W(IDX_W)) uPeak (
    .clk(clk), .rstN(rstN), .strb(strb), .candIdx(candIdx),
    .sumRe(sumRe), .sumIm(sumIm),
    .outValid(outValid), .outIdx(outIdx), .outRe(outRe), .outIm(outIm)
  );
endmodule

// File: tb/cpsync_timing_test.sv
module cpsync_timing_test;
  localparam int NF = 512;
  localparam int NC = 128;
  localparam int NS = 640;
  localparam int MAXS = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [11:0] inRe = '0, inIm = '0;
  logic outValid;
  logic [9:0] outIdx;
  logic signed [31:0] outRe, outIm;

  int sRe [MAXS];
  int sIm [MAXS];
  int bodyRe [8][NF];
  int bodyIm [8][NF];
  int total = 0, bad = 0, winSeen = 0;
  string phaseTag = "";

  always #4 clk = ~clk;

  cpsync_timing uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inRe(inRe), .inIm(inIm),
    .outValid(outValid), .outIdx(outIdx), .outRe(outRe), .outIm(outIm)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, phaseTag, act, exp);
    end
  endtask

  // brute-force winner of period w: largest re^2+im^2 (R2), first on ties (R3)
  function automatic void expWin(input int w, output int eIdx, output longint eRe, output longint eIm);
    longint best = -1;
    eIdx = 0; eRe = 0; eIm = 0;
    for (int c = 0; c < NS; c++) begin
      int k = w * NS + c + NS - 1;
      longint re = 0, im = 0, mg;
      for (int j = k - NC + 1; j <= k; j++) begin
        longint a = sRe[j-NF], b = sIm[j-NF], cc = sRe[j], d = sIm[j];
        re += a * cc + b * d;
        im += b * cc - a * d;
      end
      mg = re * re + im * im;
      if (mg > best) begin
        best = mg; eIdx = c; eRe = re; eIm = im;
      end
    end
  endfunction

  function automatic int clampS(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic genOfdm(input int n, input int off, input int noise);
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < NF; i++) begin
        bodyRe[s][i] = int'($urandom % 4095) - 2047;
        bodyIm[s][i] = int'($urandom % 4095) - 2047;
      end
    for (int i = 0; i < n; i++) begin
      int pos = (i + off) % NS;
      int sym = (i + off) / NS;
      int bi = (pos < NC) ? pos + NF - NC : pos - NC;
      int nr = (noise > 0) ? int'($urandom % (2 * noise + 1)) - noise : 0;
      int ni = (noise > 0) ? int'($urandom % (2 * noise + 1)) - noise : 0;
      sRe[i] = clampS(bodyRe[sym][bi] + nr);
      sIm[i] = clampS(bodyIm[sym][bi] + ni);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    winSeen = 0;
  endtask

  task automatic sendRange(input int from, input int upto, input bit gaps);
    for (int i = from; i < upto; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        int idle = 1 + int'($urandom % 3);
        inValid = 1'b0;
        repeat (idle) @(negedge clk);
      end
      inValid = 1'b1; inRe = 12'(sRe[i]); inIm = 12'(sIm[i]);
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  // every report compared with the brute-force period result (R1, R4)
  always @(negedge clk) begin
    if (rstN && outValid) begin
      int eIdx; longint eRe, eIm;
      expWin(winSeen, eIdx, eRe, eIm);
      chk(int'(outIdx) == eIdx, "R4 index", longint'(outIdx), longint'(eIdx));
      chk(longint'(outRe) == eRe, "R1 sum re", longint'(outRe), eRe);
      chk(longint'(outIm) == eIm, "R1 sum im", longint'(outIm), eIm);
      winSeen++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(4321));

    // R9 reset state
    doReset();
    @(negedge clk);
    chk(outValid == 1'b0, "R9 valid", longint'(outValid), 0);
    chk(outIdx == '0, "R9 idx", longint'(outIdx), 0);
    chk(outRe == '0 && outIm == '0, "R9 sum", longint'(outRe), 0);

    // random symbols, random idle gaps (R7, R2)
    phaseTag = "gapped R7";
    genOfdm(2600, 300, 0);
    sendRange(0, 2600, 1'b1);
    repeat (5) @(negedge clk);
    chk(winSeen == 3, "R5 report count", longint'(winSeen), 3);

    // noisy symbols, gapless (R7, R2)
    doReset();
    phaseTag = "gapless R2";
    genOfdm(1950, 17, 40);
    sendRange(0, 1950, 1'b0);
    repeat (5) @(negedge clk);
    chk(winSeen == 2, "R5 report count", longint'(winSeen), 2);

    // full scale constant stream: all candidates tie (R3), no overflow (R8)
    doReset();
    phaseTag = "tie R3 fullscale R8";
    for (int i = 0; i < MAXS; i++) begin sRe[i] = -2048; sIm[i] = -2048; end
    sendRange(0, 1278, 1'b0);
    repeat (6) @(negedge clk);
    chk(winSeen == 0, "R6 no report before fill", longint'(winSeen), 0);
    inValid = 1'b1; inRe = 12'(sRe[1278]); inIm = 12'(sIm[1278]);
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    chk(outValid == 1'b1, "R5 latency", longint'(outValid), 1);
    chk(outIdx == '0, "R3 earliest on tie", longint'(outIdx), 0);
    chk(longint'(outRe) == 64'sd1073741824, "R8 full scale re", longint'(outRe), 64'sd1073741824);
    @(negedge clk);
    chk(outValid == 1'b0, "R5 single cycle", longint'(outValid), 0);
    repeat (4) @(negedge clk);
    chk(winSeen == 1, "R6 first report", longint'(winSeen), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule